// File: doc/BRIEF.md
# Always-On Power Status and Interrupt Register

This block is a small control, status and interrupt register that stays usable while the main system clock of the chip is stopped. It is clocked by a slow, always-running clock. The host reads it through a purely combinational path, and host writes take effect on the next edge of that slow clock. Nothing passes through a staging register on the way.

The register holds four kinds of bits:

- a live copy of the link power status level;
- a live clock-stopped flag, the inverse of system clock activity, whose stop event can raise an interrupt;
- one sticky pending bit per external event source, set by a rising edge of that source and cleared by writing one;
- one interrupt enable per interrupt source.

All input levels are first synchronized into the slow clock domain. The interrupt request is the OR of every pending bit whose enable is set.

Top module: `psi_reg`

## Requirements
- R1: Bit 0 of the read data reads as the link power status input. It follows a change on that input two clock edges after the change.
- R2: Bit 1 of the read data reads 1 while the system-clock-active input is 0, and reads 0 while that input is 1. It follows a change two clock edges after the change.
- R3: A falling edge of the system-clock-active input latches a hidden clock-stop pending flag on the third clock edge after the fall. With the clock-stop enable (bit 5) set, irq_o then asserts. A host write with bit 1 equal to 1 clears that flag.
- R4: A rising edge of event input k sets sticky bit 2+k on the third clock edge after the rise. The bit stays set after the event input returns low, whether or not its enable is set.
- R5: A host write with a 1 in a sticky bit position clears that bit at the next clock edge. A 0 in that position leaves the bit unchanged.
- R6: If an event edge and a write-one clear reach the same sticky bit on the same clock edge, the bit stays set.
- R7: Every host write loads the enable field from the write data at the next clock edge. Bit 5 is the clock-stop enable and bits 6 to 8 are the event enables, with event k at bit 6+k. The field holds its value when there is no write. The enable field reads back at the same positions.
- R8: irq_o is high exactly when some pending bit has its enable set. It falls on the same clock edge that clears the last enabled pending bit or disables it.
- R9: Reset is asynchronous. While rst_ni is low, with no clock edge needed, the read data is 0x002 (every bit 0 except the clock-stopped flag) and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running low-frequency clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_pwr_i | input | 1 | Link power status level |
| sys_clk_act_i | input | 1 | High while the main system clock runs |
| evt_i | input | 3 | Event sources, one per sticky bit; a rising edge is the event |
| wr_en_i | input | 1 | Host write strobe, sampled on clk_i |
| wr_data_i | input | 9 | Host write data: write-one-to-clear bits and the enable field |
| rd_data_o | output | 9 | Combinational read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Each result has a fixed latency in clk_i edges:

- Live status bits change two edges after their input changes.
- Event and clock-stop captures land on the third edge after the input edge.
- Write effects, both clears and enable loads, land on the first edge after the write.
- A reset shows on the read data at once, with no edge needed.

The bench drives every input on the falling clock edge. It then waits the exact number of rising edges for the result being checked and samples on a later falling edge. For the two-edge status latency, it also samples one edge early to show that the value has not moved yet. The case where a set and a clear reach a sticky bit on the same edge is timed so that the write lands on exactly the capture edge.

// File: rtl/psi_pkg.sv
package psi_pkg;
  parameter int unsigned N_EVT_DEF = 3;
  parameter int unsigned SYNC_DEF  = 2;

  // layout: [0] link power, [1] clock stopped, events, clock enable, event enables
  function automatic int unsigned reg_width(input int unsigned n_evt);
    return 2 * n_evt + 3;
  endfunction
endpackage

// File: rtl/psi_sync.sv
module psi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/psi_sticky.sv
module psi_sticky #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    // set has priority over a same-edge clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[b] <= 1'b0;
      else         q_o[b] <= set_i[b] | (q_o[b] & ~clr_i[b]);
    end
  end
endmodule

// File: rtl/psi_reg.sv
module psi_reg #(
  parameter int unsigned N_EVT  = psi_pkg::N_EVT_DEF,
  parameter int unsigned SYNC_N = psi_pkg::SYNC_DEF,
  parameter int unsigned REG_W  = psi_pkg::reg_width(N_EVT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_pwr_i,
  input  logic             sys_clk_act_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);
  localparam int unsigned OFF_BIT = 1;
  localparam int unsigned EV_LO   = 2;
  localparam int unsigned EV_HI   = EV_LO + N_EVT - 1;
  localparam int unsigned EN_LO   = EV_HI + 1;
  localparam int unsigned EN_HI   = EN_LO + N_EVT;
  localparam int unsigned SRC_N   = N_EVT + 1;

  logic [N_EVT+1:0] raw_in, syn_q;
  logic             lps_s, act_s, act_d;
  logic [N_EVT-1:0] ev_s, ev_d, ev_rise, ev_clr, ev_pend;
  logic             off_fall, off_clr, off_pend;
  logic [SRC_N-1:0] en_q, pend;

  assign raw_in = {evt_i, sys_clk_act_i, link_pwr_i};

  psi_sync #(.W(N_EVT + 2), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_q)
  );

  assign lps_s = syn_q[0];
  assign act_s = syn_q[1];
  assign ev_s  = syn_q[N_EVT+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_d <= 1'b0;
      ev_d  <= '0;
    end else begin
      act_d <= act_s;
      ev_d  <= ev_s;
    end
  end

  assign ev_rise  = ev_s & ~ev_d;
  assign off_fall = act_d & ~act_s;
  assign ev_clr   = wr_en_i ? wr_data_i[EV_HI:EV_LO] : '0;
  assign off_clr  = wr_en_i & wr_data_i[OFF_BIT];

  psi_sticky #(.W(SRC_N)) u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i ({ev_rise, off_fall}),
    .clr_i ({ev_clr, off_clr}),
    .q_o   ({ev_pend, off_pend})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (wr_en_i) en_q <= wr_data_i[EN_HI:EN_LO];
  end

  assign pend      = {ev_pend, off_pend};
  assign irq_o     = |(pend & en_q);
  assign rd_data_o = {en_q, ev_pend, ~act_s, lps_s};
endmodule

// File: rtl/psi_reg_chk.sv
module psi_reg_chk #(
  parameter int unsigned N_EVT = 3,
  parameter int unsigned REG_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_o
);
  localparam int unsigned EV_LO = 2;
  localparam int unsigned EV_HI = EV_LO + N_EVT - 1;
  localparam int unsigned EN_LO = EV_HI + 1;
  localparam int unsigned EN_HI = EN_LO + N_EVT;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rd_data_o[EN_HI:EN_LO] != '0)); // R8

  AST_STICKY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((rd_data_o[EV_HI:EV_LO] | ~$past(rd_data_o[EV_HI:EV_LO])) == '1)); // R4

  AST_ENABLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[EN_HI:EN_LO] == $past(wr_data_i[EN_HI:EN_LO]))); // R7

  AST_ENABLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o[EN_HI:EN_LO])); // R7

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!irq_o && rd_data_o[EN_HI:EN_LO] == '0)); // R9
endmodule

bind psi_reg psi_reg_chk #(.N_EVT(N_EVT), .REG_W(REG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o)
);

// File: tb/psi_reg_test.sv
module psi_reg_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       link_pwr_i = 1'b0;
  logic       sys_clk_act_i = 1'b0;
  logic [2:0] evt_i = '0;
  logic       wr_en_i = 1'b0;
  logic [8:0] wr_data_i = '0;
  logic [8:0] rd_data_o;
  logic       irq_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  psi_reg uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .link_pwr_i   (link_pwr_i),
    .sys_clk_act_i(sys_clk_act_i),
    .evt_i        (evt_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .irq_o        (irq_o)
  );

  // {link, act, evt[2:0], wr, wdata[8:0], exp_rd[8:0], exp_irq}; 3 edges per row
  localparam logic [24:0] TBL [14] = '{
    {1'b1, 1'b1, 3'b000, 1'b0, 9'h000, 9'h001, 1'b0},  // R1 R2
    {1'b1, 1'b1, 3'b001, 1'b0, 9'h000, 9'h005, 1'b0},  // R4
    {1'b1, 1'b1, 3'b000, 1'b0, 9'h000, 9'h005, 1'b0},  // R4 stays
    {1'b1, 1'b1, 3'b000, 1'b1, 9'h000, 9'h005, 1'b0},  // R5 zero no effect
    {1'b1, 1'b1, 3'b000, 1'b1, 9'h004, 9'h001, 1'b0},  // R5 clear
    {1'b1, 1'b1, 3'b010, 1'b1, 9'h1C0, 9'h1C9, 1'b1},  // R7 R8
    {1'b1, 1'b1, 3'b000, 1'b1, 9'h1C8, 9'h1C1, 1'b0},  // R5 R8
    {1'b1, 1'b0, 3'b000, 1'b1, 9'h020, 9'h023, 1'b1},  // R2 R3
    {1'b1, 1'b0, 3'b000, 1'b1, 9'h022, 9'h023, 1'b0},  // R3 ack
    {1'b0, 1'b1, 3'b000, 1'b0, 9'h000, 9'h020, 1'b0},  // R1 R2
    {1'b0, 1'b1, 3'b100, 1'b0, 9'h000, 9'h030, 1'b0},  // R4 disabled
    {1'b0, 1'b1, 3'b000, 1'b1, 9'h100, 9'h110, 1'b1},  // R7 R8
    {1'b0, 1'b1, 3'b000, 1'b1, 9'h000, 9'h010, 1'b0},  // R8 disable
    {1'b0, 1'b1, 3'b000, 1'b1, 9'h010, 9'h000, 1'b0}   // R5
  };

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic host_wr(input logic [8:0] d);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    step(1);
    wr_en_i   = 1'b0;
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    #1 check("R9 reset state", {rd_data_o, irq_o}, {9'h002, 1'b0});

    for (int i = 0; i < 14; i++) begin
      link_pwr_i    = TBL[i][24];
      sys_clk_act_i = TBL[i][23];
      evt_i         = TBL[i][22:20];
      wr_en_i       = TBL[i][19];
      wr_data_i     = TBL[i][18:10];
      step(1);
      wr_en_i = 1'b0;
      step(2);
      check($sformatf("R1-table row %0d", i), {rd_data_o, irq_o}, TBL[i][9:0]);
    end

    // R6: write-one clear lands on the capture edge
    evt_i = 3'b001;
    step(2);
    host_wr(9'h004);
    check("R6 set wins", {rd_data_o, irq_o}, {9'h004, 1'b0});
    evt_i = 3'b000;
    step(3);
    host_wr(9'h004);
    check("R5 clear", {rd_data_o, irq_o}, {9'h000, 1'b0});

    // R8: irq tracks clear and disable on the same edge
    host_wr(9'h040);
    evt_i = 3'b001;
    step(3);
    check("R8 raise", {rd_data_o, irq_o}, {9'h044, 1'b1});
    evt_i = 3'b000;
    host_wr(9'h044);
    check("R8 clear drop", {rd_data_o, irq_o}, {9'h040, 1'b0});
    step(2);
    evt_i = 3'b001;
    step(3);
    check("R8 raise again", {rd_data_o, irq_o}, {9'h044, 1'b1});
    host_wr(9'h000);
    check("R8 disable drop", {rd_data_o, irq_o}, {9'h004, 1'b0});
    evt_i = 3'b000;

    // R1: exact two-edge latency
    link_pwr_i = 1'b1;
    step(1);
    check("R1 one edge", {9'b0, rd_data_o[0]}, 10'd0);
    step(1);
    check("R1 two edges", {9'b0, rd_data_o[0]}, 10'd1);

    // R9: asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1 check("R9 async reset", {rd_data_o, irq_o}, {9'h002, 1'b0});
    step(1);
    rst_ni = 1'b1;
    step(1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule